// File: doc/BRIEF.md
# Accessory Address Checksum Generator

This block protects a 16-bit accessory address word with a 5-bit checksum. The upper eleven bits of the word carry the address. The lowest five bits are the checksum slot. The block works out the checksum that belongs to the address bits and puts that value on its own output. It also returns a rebuilt 16-bit word, with the address bits kept in the upper part and the freshly computed checksum placed in the lower part. A match flag says whether the checksum that arrived in the low bits of the incoming word equals the computed one.

The checksum is a 5-bit division remainder with generator 0x15. The top five address bits load the remainder directly. The block then shifts in the other six address bits, most significant first, and after them five zero bits. That makes eleven shift-and-reduce steps. The unit has no clock and no reset, so the outputs follow the input word combinationally. A transmitter uses the rebuilt word and the checksum output. A receiver uses the match flag.

Top module: `addr_crc_gen`

## Requirements
- R1: The checksum output depends only on input bits 15..5. Changing input bits 4..0 leaves the checksum output unchanged.
- R2: The remainder is seeded from input bits 15..11. No initial value is added, so an all-zero address field (bits 15..5 all 0) gives a checksum of 0.
- R3: The checksum equals the result of eleven serial steps. Each step samples remainder bit 4, shifts the 5-bit remainder left by one, and inserts the next bit at bit 0. If the sampled bit was 1, the step XORs the remainder with 0x15. The bits inserted are input bits 10 down to 5, followed by five zeros. This holds for all 2048 address values.
- R4: The match output is 1 exactly when the computed checksum equals input bits 4..0, and 0 otherwise.
- R5: The rebuilt word carries input bits 15..5 unchanged in its bits 15..5, and the computed checksum in its bits 4..0.
- R6: The outputs are purely combinational. They reflect a new input word in the same time step, with no clock. For example, input 0x0800 gives a checksum of 0x0E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_word_i | input | 16 | Address word: bits 15..5 are the address, bits 4..0 are the received checksum |
| crc_o | output | 5 | Checksum computed over bits 15..5 |
| frame_o | output | 16 | Address bits 15..5 followed by the computed checksum |
| match_o | output | 1 | 1 when bits 4..0 of the input equal crc_o |

## Verification
The bound checker evaluates four properties continuously:
- The rebuilt word keeps the address field unchanged.
- The low field of the rebuilt word carries the checksum output.
- A raised match flag implies the incoming word is already a correctly rebuilt word.
- A zero address field produces a zero checksum.

Only the bench's scenarios can show that the checksum follows the serial division for every address, and that the low input bits have no influence on it. The bench sweeps all 2048 addresses, each with a correct and a corrupted low field, against its own bit-serial model.

// File: rtl/addr_crc_pkg.sv
package addr_crc_pkg;

   // Implementation variant of the remainder network
   typedef enum logic {
      CRC_IMPL_STAGES = 1'b0,   // one instantiated stage per step
      CRC_IMPL_LOOP   = 1'b1    // single always_comb loop
   } crc_impl_e;

   localparam int unsigned CRC_WORD_W_DEF = 16;
   localparam int unsigned CRC_W_DEF      = 5;
   localparam logic [4:0]  CRC_POLY_DEF   = 5'h15;

endpackage

// File: rtl/addr_crc_stage.sv
module addr_crc_stage #(
   parameter int unsigned    CRC_W = 5,
   parameter logic [CRC_W-1:0] POLY = 5'h15
) (
   input  logic [CRC_W-1:0] rem_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] rem_o
);

   logic             top_bit;
   logic [CRC_W-1:0] shifted;

   always_comb begin
      top_bit = rem_i[CRC_W-1];
      shifted = {rem_i[CRC_W-2:0], bit_i};
      rem_o   = top_bit ? (shifted ^ POLY) : shifted;
   end

endmodule

// File: rtl/addr_crc_core.sv
module addr_crc_core
   import addr_crc_pkg::*;
#(
   parameter int unsigned      WORD_W = 16,
   parameter int unsigned      CRC_W  = 5,
   parameter logic [CRC_W-1:0] POLY   = 5'h15,
   parameter crc_impl_e        IMPL   = CRC_IMPL_STAGES,
   localparam int unsigned     MSG_W  = WORD_W - CRC_W
) (
   input  logic [MSG_W-1:0] msg_i,
   output logic [CRC_W-1:0] crc_o
);

   // Bits shifted in after the seed, followed by CRC_W zeros
   localparam int unsigned FEED_W = MSG_W - CRC_W;
   localparam int unsigned STEPS  = MSG_W;

   logic [CRC_W-1:0] seed;
   logic [STEPS-1:0] stream;

   assign seed   = msg_i[MSG_W-1 -: CRC_W];
   assign stream = {msg_i[FEED_W-1:0], {CRC_W{1'b0}}};

   generate
      if (IMPL == CRC_IMPL_STAGES) begin : g_stages
         logic [CRC_W-1:0] rem [0:STEPS];
         assign rem[0] = seed;
         for (genvar i = 0; i < STEPS; i++) begin : g_step
            addr_crc_stage #(
               .CRC_W (CRC_W),
               .POLY  (POLY)
            ) u_stage (
               .rem_i (rem[i]),
               .bit_i (stream[STEPS-1-i]),
               .rem_o (rem[i+1])
            );
         end
         assign crc_o = rem[STEPS];
      end else begin : g_loop
         always_comb begin
            logic [CRC_W-1:0] r;
            logic             hi;
            r = seed;
            for (int i = 0; i < STEPS; i++) begin
               hi = r[CRC_W-1];
               r  = {r[CRC_W-2:0], stream[STEPS-1-i]};
               if (hi) r = r ^ POLY;
            end
            crc_o = r;
         end
      end
   endgenerate

endmodule

// File: rtl/addr_crc_cmp.sv
module addr_crc_cmp #(
   parameter int unsigned CRC_W = 5
) (
   input  logic [CRC_W-1:0] calc_i,
   input  logic [CRC_W-1:0] rx_i,
   output logic             eq_o
);

   logic [CRC_W-1:0] diff;

   assign diff = calc_i ^ rx_i;
   assign eq_o = ~|diff;

endmodule

// File: rtl/addr_crc_gen.sv
module addr_crc_gen
   import addr_crc_pkg::*;
#(
   parameter int unsigned      WORD_W = CRC_WORD_W_DEF,
   parameter int unsigned      CRC_W  = CRC_W_DEF,
   parameter logic [CRC_W-1:0] POLY   = CRC_POLY_DEF,
   parameter crc_impl_e        IMPL   = CRC_IMPL_STAGES
) (
   input  logic [WORD_W-1:0] addr_word_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic [WORD_W-1:0] frame_o,
   output logic              match_o
);

   localparam int unsigned MSG_W = WORD_W - CRC_W;

   generate
      if (CRC_W < 2) begin : g_bad_crc_w
         $error("addr_crc_gen: CRC_W must be at least 2");
      end
      if (MSG_W < CRC_W) begin : g_bad_msg_w
         $error("addr_crc_gen: address field narrower than checksum");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("addr_crc_gen: generator must have its lowest bit set");
      end
   endgenerate

   logic [MSG_W-1:0] msg;
   logic [CRC_W-1:0] rx_crc;
   logic [CRC_W-1:0] calc_crc;

   assign msg    = addr_word_i[WORD_W-1:CRC_W];
   assign rx_crc = addr_word_i[CRC_W-1:0];

   addr_crc_core #(
      .WORD_W (WORD_W),
      .CRC_W  (CRC_W),
      .POLY   (POLY),
      .IMPL   (IMPL)
   ) u_core (
      .msg_i  (msg),
      .crc_o  (calc_crc)
   );

   addr_crc_cmp #(
      .CRC_W  (CRC_W)
   ) u_cmp (
      .calc_i (calc_crc),
      .rx_i   (rx_crc),
      .eq_o   (match_o)
   );

   assign crc_o   = calc_crc;
   assign frame_o = {msg, calc_crc};

endmodule

// File: rtl/addr_crc_gen_chk.sv
module addr_crc_gen_chk #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CRC_W  = 5
) (
   input logic [WORD_W-1:0] addr_word_i,
   input logic [CRC_W-1:0]  crc_o,
   input logic [WORD_W-1:0] frame_o,
   input logic              match_o
);

   always_comb begin
      // R5
      frame_addr_chk: assert (frame_o[WORD_W-1:CRC_W] == addr_word_i[WORD_W-1:CRC_W]);
      // R5
      frame_crc_chk: assert (frame_o[CRC_W-1:0] == crc_o);
      // R4
      match_frame_chk: assert (!match_o || (frame_o == addr_word_i));
      // R2
      zero_seed_chk: assert ((addr_word_i[WORD_W-1:CRC_W] != '0) || (crc_o == '0));
   end

endmodule

bind addr_crc_gen addr_crc_gen_chk #(
   .WORD_W (WORD_W),
   .CRC_W  (CRC_W)
) u_chk (
   .addr_word_i (addr_word_i),
   .crc_o       (crc_o),
   .frame_o     (frame_o),
   .match_o     (match_o)
);

// File: tb/addr_crc_gen_bench.sv
module addr_crc_gen_bench;

   typedef struct packed {
      logic [15:0] word;
      logic [4:0]  crc;
      logic        match;
      logic [15:0] frame;
   } exp_t;

   logic        clk = 1'b0;
   logic [15:0] addr_word;
   logic [4:0]  crc;
   logic [15:0] frame;
   logic        match;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   int unsigned cycles   = 0;
   bit          done     = 1'b0;
   exp_t        sb_q[$];

   always #2 clk = ~clk;   // 250 MHz

   addr_crc_gen u_addr_crc_gen (
      .addr_word_i (addr_word),
      .crc_o       (crc),
      .frame_o     (frame),
      .match_o     (match)
   );

   // Bit-serial reference model of the checksum
   function automatic logic [4:0] ref_crc(input logic [10:0] a);
      logic [4:0] r;
      logic       hi;
      logic       b;
      r = a[10:6];
      for (int i = 0; i < 11; i++) begin
         b  = (i < 6) ? a[5-i] : 1'b0;
         hi = r[4];
         r  = {r[3:0], b};
         if (hi) r = r ^ 5'h15;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp, input logic [15:0] w);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s word=%h actual=%h expected=%h", req, w, act, exp);
      end
   endtask

   // Driver: applies one word per cycle and queues its expectation
   task automatic drive(input logic [15:0] w);
      exp_t e;
      @(posedge clk);
      addr_word = w;
      e.word  = w;
      e.crc   = ref_crc(w[15:5]);
      e.match = (e.crc == w[4:0]);
      e.frame = {w[15:5], e.crc};
      sb_q.push_back(e);
   endtask

   // Monitor: compares away from the driving edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check("R3", {11'd0, crc}, {11'd0, e.crc}, e.word);
         check("R4", {15'd0, match}, {15'd0, e.match}, e.word);
         check("R5", frame, e.frame, e.word);
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [4:0] c_a;
      logic [4:0] c_b;
      addr_word = 16'h0000;
      #1;
      // R2: zero address field gives zero checksum, and matches a zero low field
      check("R2", {11'd0, crc}, 16'd0, addr_word);
      check("R4", {15'd0, match}, 16'd1, addr_word);
      // R6: combinational response in the same time step, no clock edge
      addr_word = 16'h0800;
      #1;
      check("R6", {11'd0, crc}, 16'h000E, addr_word);
      // R1: low bits do not influence the checksum
      addr_word = 16'h081F;
      #1;
      check("R1", {11'd0, crc}, 16'h000E, addr_word);
      // Full sweep: each address with a correct and a corrupted low field
      for (int a = 0; a < 2048; a++) begin
         logic [4:0] good;
         good = ref_crc(a[10:0]);
         drive({a[10:0], good});
         drive({a[10:0], good ^ 5'h01});
      end
      @(posedge clk);
      @(negedge clk);
      // R1: direct comparison across two low patterns for one address
      addr_word = 16'hA5A0;
      #1;
      c_a = crc;
      addr_word = 16'hA5BF;
      #1;
      c_b = crc;
      check("R1", {11'd0, c_b}, {11'd0, c_a}, addr_word);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule